// File: doc/BRIEF.md
# Link Training Rate Climb Sequencer

This block is an abstract controller for the bring-up of a serial link. It takes the link out of reset and waits for a partner receiver. It then runs the two ordered-set exchanges and reaches the active state at generation 1. From there it raises the data rate toward a negotiated ceiling, one speed change at a time. A modelled PHY and link partner drive it through single-cycle handshake strobes. The controller reports its state as a fixed binary code, together with the current rate, an equalization request and a link-up flag.

Three climb policies can be selected:
- **Full:** equalize at every rate from generation 3 upward.
- **Top only:** make one speed change to the ceiling and equalize there.
- **No equalization:** make one speed change to the ceiling with no equalization phase.

Every policy first spends at least one cycle in the active state at the base rate. Each speed change goes through the recovery state. Every waiting state is guarded by a cycle-count timeout, so a stalled partner sends the link back to detect instead of hanging it.

Top module: `lts_seq`

## Requirements
- R1: While reset is low and on the first cycle after it, the outputs are fixed. `state_o` is 0 (detect), `rate_o` is 1, and `eq_req_o` and `link_up_o` are both 0.
- R2: The forward path is set by these state codes and strobes:
  - Detect (0) moves to polling (1) on `rx_present_i`.
  - Polling moves to configuration (2) on `ts_done_i`.
  - Configuration moves to active (3) on `ts_done_i`, at rate 1.
  - `link_up_o` is 1 from the first active cycle onward.
- R3: The rate changes only while leaving recovery (4), and only on `spd_done_i` when a higher step is pending. When no step is pending, recovery returns to active on `ts_done_i`.
- R4: With `mode_i` = 0 (full), the climb from rate 1 visits rate 3, then 4, then 5, up to the ceiling. Each of those rates is entered through the equalization state (5), and equalization returns to recovery on `eq_done_i`.
- R5: With `mode_i` = 1 (top only), there is one speed change, straight to the ceiling. It is followed by a single equalization phase when the ceiling is 3 or more.
- R6: With `mode_i` = 2 or 3, there is one speed change straight to the ceiling and no equalization phase.
- R7: The ceiling is the smallest of `local_max_i`, `partner_max_i` and MAX_GEN (default 5). A value of 0 is treated as 1. Policy steps above the ceiling are skipped. For example, under full mode with a ceiling of 2 the link moves from 1 to 2 without equalizing.
- R8: Once in active with no step pending, the state and rate hold until `err_i` or `retrain_i`. Either of these sends the link to recovery at the same rate.
- R9: Polling, configuration, recovery and equalization each time out after TMO_CYC cycles without progress. Progress means a change of state or rate. On timeout the link returns to detect with rate 1 and `link_up_o` 0.
- R10: `err_i` in polling, configuration, recovery or equalization sends the link to detect on the next edge. It takes precedence over every other strobe, and it clears `link_up_o` and resets the rate to 1.
- R11: `eq_req_o` is 1 exactly in the cycles where `state_o` is 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Climb policy: 0 full, 1 top only, 2/3 no equalization |
| local_max_i | input | 3 | Highest generation supported locally |
| partner_max_i | input | 3 | Highest generation advertised by the partner |
| rx_present_i | input | 1 | Partner receiver detected |
| ts_done_i | input | 1 | Training-sequence exchange finished |
| eq_done_i | input | 1 | Equalization finished |
| spd_done_i | input | 1 | Speed change finished |
| err_i | input | 1 | Link error |
| retrain_i | input | 1 | Retrain request |
| state_o | output | 3 | State code: 0 detect, 1 polling, 2 configuration, 3 active, 4 recovery, 5 equalization |
| rate_o | output | 3 | Current generation, 1 to MAX_GEN |
| eq_req_o | output | 1 | Equalization phase in progress |
| link_up_o | output | 1 | Link has reached active and not dropped since |

## Verification
The assertions assume that `mode_i`, `local_max_i` and `partner_max_i` stay constant between resets. The ceiling and the equalization rule are read from them combinationally, so a mid-run change would break the rate-bound and equalization-rate properties. The bench changes these three inputs only while reset is held low. It draws the handshake strobes every cycle from per-trial probabilities, which are sometimes set to zero on purpose so that each timeout path is reached.

// File: rtl/lts_pkg.sv
package lts_pkg;

  localparam int RATE_W = 3;
  typedef logic [RATE_W-1:0] rate_t;

  // First generation that needs an equalization phase
  localparam rate_t EQ_FLOOR = rate_t'(3);

  localparam logic [1:0] POL_FULL = 2'd0;
  localparam logic [1:0] POL_TOP  = 2'd1;

  typedef enum logic [2:0] {
    ST_DETECT = 3'd0,
    ST_POLL   = 3'd1,
    ST_CFG    = 3'd2,
    ST_ACTIVE = 3'd3,
    ST_RECOV  = 3'd4,
    ST_EQ     = 3'd5
  } lts_state_e;

  // Negotiated ceiling: min of both sides and the build limit, never below 1
  function automatic rate_t link_cap(rate_t a, rate_t b, rate_t lim);
    rate_t lo;
    lo = (a < b) ? a : b;
    if (lo > lim) lo = lim;
    if (lo == '0) lo = rate_t'(1);
    return lo;
  endfunction

  // Next rate the policy asks for, or cur when the climb is finished
  function automatic rate_t step_target(logic [1:0] pol, rate_t cur, rate_t cap);
    if (cur >= cap) return cur;
    if (pol == POL_FULL) begin
      if (cur < EQ_FLOOR && cap >= EQ_FLOOR) return EQ_FLOOR;
      return rate_t'(cur + 1'b1);
    end
    return cap;
  endfunction

  function automatic logic needs_eq(logic [1:0] pol, rate_t r);
    return (pol == POL_FULL || pol == POL_TOP) && (r >= EQ_FLOOR);
  endfunction

endpackage

// File: rtl/lts_rate_plan.sv
module lts_rate_plan
  import lts_pkg::*;
#(
  parameter int MAX_GEN = 5
) (
  input  logic [1:0] mode_i,
  input  rate_t      cur_i,
  input  rate_t      local_i,
  input  rate_t      partner_i,
  output rate_t      cap_o,
  output rate_t      nxt_o,
  output logic       pend_o,
  output logic       eq_o
);

  localparam rate_t GEN_LIM = rate_t'(MAX_GEN);

  always_comb begin
    cap_o  = link_cap(local_i, partner_i, GEN_LIM);
    nxt_o  = step_target(mode_i, cur_i, cap_o);
    pend_o = (nxt_o != cur_i);
    eq_o   = needs_eq(mode_i, nxt_o);
  end

endmodule

// File: rtl/lts_tmo.sv
module lts_tmo #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  output logic expired_o
);

  localparam int CW = $clog2(LIMIT) + 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (clr_i)       cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign expired_o = (cnt == LAST);

  // R9: the window advances by one every quiet cycle until it expires
  a_r9_window_runs: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i && !expired_o |=> cnt == $past(cnt) + 1'b1);

endmodule

// File: rtl/lts_seq.sv
module lts_seq
  import lts_pkg::*;
#(
  parameter int MAX_GEN = 5,
  parameter int TMO_CYC = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic [2:0] local_max_i,
  input  logic [2:0] partner_max_i,
  input  logic       rx_present_i,
  input  logic       ts_done_i,
  input  logic       eq_done_i,
  input  logic       spd_done_i,
  input  logic       err_i,
  input  logic       retrain_i,
  output logic [2:0] state_o,
  output logic [2:0] rate_o,
  output logic       eq_req_o,
  output logic       link_up_o
);

  localparam rate_t BASE = rate_t'(1);

  lts_state_e st_q, st_d;
  rate_t      rate_q, rate_d;
  logic       up_q, up_d;

  rate_t cap, nxt;
  logic  step_pend, step_eq, tmo, progress;

  lts_rate_plan #(.MAX_GEN(MAX_GEN)) u_plan (
    .mode_i    (mode_i),
    .cur_i     (rate_q),
    .local_i   (local_max_i),
    .partner_i (partner_max_i),
    .cap_o     (cap),
    .nxt_o     (nxt),
    .pend_o    (step_pend),
    .eq_o      (step_eq)
  );

  lts_tmo #(.LIMIT(TMO_CYC)) u_tmo (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (progress),
    .expired_o (tmo)
  );

  always_comb begin
    st_d   = st_q;
    rate_d = rate_q;
    unique case (st_q)
      ST_DETECT: if (rx_present_i) st_d = ST_POLL;
      ST_POLL: begin
        if (err_i)          st_d = ST_DETECT;
        else if (ts_done_i) st_d = ST_CFG;
        else if (tmo)       st_d = ST_DETECT;
      end
      ST_CFG: begin
        if (err_i)          st_d = ST_DETECT;
        else if (ts_done_i) st_d = ST_ACTIVE;
        else if (tmo)       st_d = ST_DETECT;
      end
      ST_ACTIVE: if (err_i || retrain_i || step_pend) st_d = ST_RECOV;
      ST_RECOV: begin
        if (err_i) st_d = ST_DETECT;
        else if (step_pend) begin
          if (spd_done_i) begin
            rate_d = nxt;
            if (step_eq) st_d = ST_EQ;
          end else if (tmo) st_d = ST_DETECT;
        end
        else if (ts_done_i) st_d = ST_ACTIVE;
        else if (tmo)       st_d = ST_DETECT;
      end
      ST_EQ: begin
        if (err_i)          st_d = ST_DETECT;
        else if (eq_done_i) st_d = ST_RECOV;
        else if (tmo)       st_d = ST_DETECT;
      end
      default: st_d = ST_DETECT;
    endcase
    if (st_d == ST_DETECT) rate_d = BASE;
    if (st_d == ST_ACTIVE)      up_d = 1'b1;
    else if (st_d == ST_DETECT) up_d = 1'b0;
    else                        up_d = up_q;
  end

  assign progress = (st_d != st_q) || (rate_d != rate_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_DETECT;
      rate_q <= BASE;
      up_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      rate_q <= rate_d;
      up_q   <= up_d;
    end
  end

  assign state_o   = st_q;
  assign rate_o    = rate_q;
  assign eq_req_o  = (st_q == ST_EQ);
  assign link_up_o = up_q;

  // R2: a present receiver always starts polling
  a_r2_detect_exit: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_DETECT && rx_present_i |=> st_q == ST_POLL);

  // R3: the rate only climbs out of recovery
  a_r3_climb_in_recovery: assert property (@(posedge clk) disable iff (!rst_n)
    rate_q > $past(rate_q) |-> $past(st_q) == ST_RECOV);

  // R7: the rate never exceeds the negotiated ceiling
  a_r7_under_cap: assert property (@(posedge clk) disable iff (!rst_n)
    rate_o <= cap);

  // R8: a finished link holds still unless disturbed
  a_r8_hold_active: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_ACTIVE && !err_i && !retrain_i && !step_pend
    |=> st_q == ST_ACTIVE && $stable(rate_o));

  // R10: an error in a training state drops the link next cycle
  a_r10_error_drop: assert property (@(posedge clk) disable iff (!rst_n)
    err_i && (st_q == ST_POLL || st_q == ST_CFG || st_q == ST_RECOV || st_q == ST_EQ)
    |=> st_q == ST_DETECT && !link_up_o && rate_o == BASE);

  // R9: link-up only falls on the way back to detect
  a_r9_drop_to_detect: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(link_up_o) |-> st_q == ST_DETECT);

  // R11: equalization runs only at rates that call for it
  a_r11_eq_rate: assert property (@(posedge clk) disable iff (!rst_n)
    eq_req_o |-> rate_o >= 3'd3 && mode_i[1] == 1'b0);

endmodule

// File: tb/sim_lts_seq.sv
`timescale 1ns/1ps
module sim_lts_seq;

  localparam int TMO  = 16;
  localparam int MAXG = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0;
  logic [1:0] mode = '0;
  logic [2:0] lmax = 3'd5, pmax = 3'd5;
  logic       rx = 0, ts = 0, eqd = 0, spd = 0, err = 0, rtr = 0;
  logic [2:0] state_o, rate_o;
  logic       eq_req_o, link_up_o;

  lts_seq #(.MAX_GEN(MAXG), .TMO_CYC(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .local_max_i(lmax),
    .partner_max_i(pmax), .rx_present_i(rx), .ts_done_i(ts),
    .eq_done_i(eqd), .spd_done_i(spd), .err_i(err), .retrain_i(rtr),
    .state_o(state_o), .rate_o(rate_o), .eq_req_o(eq_req_o), .link_up_o(link_up_o)
  );

  int checks = 0, fails = 0;
  int m_st, m_rate, m_cnt, eq_entries;
  bit m_up, prev_eq;
  string m_tag;

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int cap_of(int l, int p);
    int c = (l < p) ? l : p;
    if (c > MAXG) c = MAXG;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int next_of(int md, int cur, int cap);
    if (cur >= cap) return cur;
    if (md != 0) return cap;
    if (cap < 3) return cap;
    return (cur < 3) ? 3 : cur + 1;
  endfunction

  function automatic bit eq_at(int md, int r);
    return (md < 2) && (r >= 3);
  endfunction

  task automatic model_step();
    int st = m_st, rt = m_rate;
    int cap = cap_of(lmax, pmax);
    int nx  = next_of(mode, m_rate, cap);
    bit expired = (m_cnt >= TMO - 1);
    string tg = "R2";
    case (m_st)
      0: if (rx) st = 1;
      1, 2: if (err) begin st = 0; tg = "R10"; end
            else if (ts) st = m_st + 1;
            else if (expired) begin st = 0; tg = "R9"; end
      3: if (err || rtr) begin st = 4; tg = "R8"; end
         else if (nx != m_rate) begin st = 4; tg = "R3"; end
         else tg = "R8";
      4: begin
        tg = "R3";
        if (err) begin st = 0; tg = "R10"; end
        else if (nx != m_rate) begin
          if (spd) begin
            rt = nx;
            tg = (cap < 3) ? "R7" : (mode == 0) ? "R4" : (mode == 1) ? "R5" : "R6";
            if (eq_at(mode, nx)) st = 5;
          end else if (expired) begin st = 0; tg = "R9"; end
        end
        else if (ts) st = 3;
        else if (expired) begin st = 0; tg = "R9"; end
      end
      5: begin
        tg = "R4";
        if (err) begin st = 0; tg = "R10"; end
        else if (eqd) st = 4;
        else if (expired) begin st = 0; tg = "R9"; end
      end
      default: st = 0;
    endcase
    if (st == 0) rt = 1;
    if (st != m_st || rt != m_rate) m_cnt = 0; else m_cnt++;
    if (st == 3) m_up = 1; else if (st == 0) m_up = 0;
    m_st = st; m_rate = rt; m_tag = tg;
  endtask

  task automatic compare();
    check(m_tag, "state", int'(state_o), m_st);
    check(m_tag, "rate", int'(rate_o), m_rate);
    check("R11", "eq_req", int'(eq_req_o), int'(m_st == 5));
    check(m_tag, "link_up", int'(link_up_o), int'(m_up));
    if (eq_req_o && !prev_eq) eq_entries++;
    prev_eq = eq_req_o;
  endtask

  task automatic do_reset(int md, int l, int p);
    @(negedge clk);
    rst_n = 0; rx = 0; ts = 0; eqd = 0; spd = 0; err = 0; rtr = 0;
    mode = 2'(md); lmax = 3'(l); pmax = 3'(p);
    repeat (2) @(negedge clk);
    check("R1", "reset state", int'(state_o), 0);
    check("R1", "reset rate", int'(rate_o), 1);
    check("R1", "reset eq_req", int'(eq_req_o), 0);
    check("R1", "reset link_up", int'(link_up_o), 0);
    m_st = 0; m_rate = 1; m_cnt = 0; m_up = 0; m_tag = "R1";
    eq_entries = 0; prev_eq = 0;
    rst_n = 1;
    model_step();
  endtask

  task automatic run(int n, int prx, int pts, int peq, int pspd, int perr, int prtr);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      rx  = ($urandom_range(0, 99) < prx);
      ts  = ($urandom_range(0, 99) < pts);
      eqd = ($urandom_range(0, 99) < peq);
      spd = ($urandom_range(0, 99) < pspd);
      err = ($urandom_range(0, 99) < perr);
      rtr = ($urandom_range(0, 99) < prtr);
      model_step();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // Clean climbs: each policy, then ceilings below the top
    for (int md = 0; md < 4; md++) begin
      do_reset(md, 5, 7);
      run(40, 100, 100, 100, 100, 0, 0);
      check(md == 0 ? "R4" : md == 1 ? "R5" : "R6", "final state", int'(state_o), 3);
      check(md == 0 ? "R4" : md == 1 ? "R5" : "R6", "final rate", int'(rate_o), 5);
      check(md == 0 ? "R4" : md == 1 ? "R5" : "R6", "eq phases", eq_entries,
            md == 0 ? 3 : md == 1 ? 1 : 0);
    end
    do_reset(0, 2, 7);
    run(40, 100, 100, 100, 100, 0, 0);
    check("R7", "cap2 rate", int'(rate_o), 2);
    check("R7", "cap2 eq phases", eq_entries, 0);
    do_reset(0, 6, 4);
    run(40, 100, 100, 100, 100, 0, 0);
    check("R7", "cap4 rate", int'(rate_o), 4);
    check("R7", "cap4 eq phases", eq_entries, 2);
    do_reset(1, 0, 0);
    run(30, 100, 100, 100, 100, 0, 0);
    check("R7", "zero cap rate", int'(rate_o), 1);
    // Stalls: polling, equalization and speed change never finish
    do_reset(0, 5, 5);
    run(3 * TMO, 100, 0, 0, 0, 0, 0);
    do_reset(0, 5, 5);
    run(4 * TMO, 100, 100, 0, 100, 0, 0);
    do_reset(2, 5, 5);
    run(4 * TMO, 100, 100, 100, 0, 0, 0);
    // Retrain and error in active
    do_reset(1, 5, 5);
    run(30, 100, 100, 100, 100, 0, 0);
    run(60, 100, 100, 100, 100, 0, 20);
    run(60, 100, 100, 100, 100, 10, 0);
    // Random trials
    for (int t = 0; t < 40; t++) begin
      do_reset($urandom_range(0, 3), $urandom_range(0, 7), $urandom_range(0, 7));
      run(400, $urandom_range(20, 100), $urandom_range(10, 100),
          $urandom_range(5, 100), $urandom_range(5, 100),
          $urandom_range(0, 3), $urandom_range(0, 3));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule